// File: doc/BRIEF.md
# Column Group Pixel Word Serializer

This block collects pixel readings from a group of image-sensor columns and streams them onto a single serial output line. Every column holds several ADC slots. One of those slots is a spare, so each column has one slot that is left out of the scan. Each slot presents two readings for its pixel: the reset-baseline sample, which is used for correlated double sampling, and the signal sample. Each reading arrives as separate gain, overrange and ADC-code fields. The block packs every reading into a 15-bit word and sends the words one bit per clock.

The scan is free-running. Columns are visited in ascending order. Inside a column, the block visits the slots that are not excluded, in ascending physical order. For each slot it sends the baseline word first and then the signal word. A one-cycle frame marker flags the first bit of every scan. A per-column selector names the slot to leave out, so the spare can take over from a faulty ADC and the slots above the excluded one close up the gap. A slot whose valid flag is low when its word is due is sent as zeros, and an underrun flag is raised for that word.

Top module: `colser_lane`

## Requirements
- R1: Each transmitted word is packed as {gain[1:0], overrange, code[11:0]}: gain in bits 14:13, overrange in bit 12, code in bits 11:0.
- R2: Words are shifted out most significant bit first, one bit per clock, 15 clocks per word, back to back with no idle cycles.
- R3: The scan visits columns 0 to NUM_COLS-1 in order. Within a column it visits the SLOTS-1 non-excluded slots in ascending physical order, sending the baseline word before the signal word of each slot.
- R4: For column c, the 3-bit field skip_sel[3c+2:3c] names the physical slot that is left out. Slots below it keep their position in the order, slots above it move down by one, and the inputs of the excluded slot have no effect on the output.
- R5: frame_mark is high for exactly one cycle, together with the first bit of the baseline word of column 0's first active slot, and is low for every other bit.
- R6: If slot_valid of the slot is low at the word's first bit, the word is sent as all zeros and underrun is high for all 15 bits of that word. Otherwise underrun is low for the whole word.
- R7: The scan repeats without gaps, so frame markers are exactly NUM_COLS*(SLOTS-1)*2*15 cycles apart (6720 with default parameters).
- R8: While rst is high and on the cycle after it, ser_out, frame_mark and underrun are low. The first bit of a scan appears in the cycle after rst falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | NUM_COLS*SLOTS | Data-present flag per slot, index column*SLOTS+slot |
| base_gain | input | NUM_COLS*SLOTS*2 | Gain code of the baseline sample per slot |
| base_ovr | input | NUM_COLS*SLOTS | Overrange bit of the baseline sample per slot |
| base_code | input | NUM_COLS*SLOTS*12 | ADC code of the baseline sample per slot |
| sig_gain | input | NUM_COLS*SLOTS*2 | Gain code of the signal sample per slot |
| sig_ovr | input | NUM_COLS*SLOTS | Overrange bit of the signal sample per slot |
| sig_code | input | NUM_COLS*SLOTS*12 | ADC code of the signal sample per slot |
| skip_sel | input | NUM_COLS*3 | Excluded physical slot per column |
| ser_out | output | 1 | Serial data bit, MSB first |
| frame_mark | output | 1 | High with the first bit of each scan |
| underrun | output | 1 | High for the bits of a word from an empty slot |

## Verification
The hardest situation to reach from the ports is an excluded slot whose inputs would visibly change the stream if the slot were used by mistake. The bench therefore moves the excluded slot from column to column, including slot 0 and an interior slot, and gives it distinct data. In the empty-slot pattern it also clears valid on slots that happen to be excluded, and a stray zero word or underrun pulse would then show up in the compared stream. A two-scan run checks that the second frame marker and its first word come exactly one scan length after the first.

// File: rtl/colser_pkg.sv
package colser_pkg;
  typedef enum logic {
    PH_BASE = 1'b0,
    PH_SIG  = 1'b1
  } phase_e;
endpackage

// File: rtl/colser_seq.sv
module colser_seq
  import colser_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int SLOTS    = 8,
  parameter int WORD_W   = 15,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SEL_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] col_idx,
  output logic [SEL_W-1:0] act_idx,
  output phase_e           phase,
  output logic             load,
  output logic             scan_first
);
  localparam int ACT = SLOTS - 1;

  logic [BIT_W-1:0] bit_q;
  logic [COL_W-1:0] col_q;
  logic [SEL_W-1:0] act_q;
  phase_e           ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      col_q <= '0;
      act_q <= '0;
      ph_q  <= PH_BASE;
    end else if (bit_q == BIT_W'(WORD_W - 1)) begin
      bit_q <= '0;
      if (ph_q == PH_SIG) begin
        ph_q <= PH_BASE;
        if (act_q == SEL_W'(ACT - 1)) begin
          act_q <= '0;
          col_q <= (col_q == COL_W'(NUM_COLS - 1)) ? '0 : col_q + 1'b1;
        end else begin
          act_q <= act_q + 1'b1;
        end
      end else begin
        ph_q <= PH_SIG;
      end
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign col_idx    = col_q;
  assign act_idx    = act_q;
  assign phase      = ph_q;
  assign load       = (bit_q == '0);
  assign scan_first = (col_q == '0) && (act_q == '0) && (ph_q == PH_BASE);
endmodule

// File: rtl/colser_slot_mux.sv
module colser_slot_mux
  import colser_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int SLOTS    = 8,
  parameter int GAIN_W   = 2,
  parameter int CODE_W   = 12,
  localparam int WORD_W  = GAIN_W + 1 + CODE_W,
  localparam int NSLOT   = NUM_COLS * SLOTS,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SEL_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [NSLOT-1:0]          slot_valid,
  input  logic [NSLOT*GAIN_W-1:0]   base_gain,
  input  logic [NSLOT-1:0]          base_ovr,
  input  logic [NSLOT*CODE_W-1:0]   base_code,
  input  logic [NSLOT*GAIN_W-1:0]   sig_gain,
  input  logic [NSLOT-1:0]          sig_ovr,
  input  logic [NSLOT*CODE_W-1:0]   sig_code,
  input  logic [NUM_COLS*SEL_W-1:0] skip_sel,
  input  logic [COL_W-1:0]          col_idx,
  input  logic [SEL_W-1:0]          act_idx,
  input  phase_e                    phase,
  output logic [WORD_W-1:0]         word,
  output logic                      word_valid
);
  logic [WORD_W-1:0] base_w [NSLOT];
  logic [WORD_W-1:0] sig_w  [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_pack
    assign base_w[g] = {base_gain[g*GAIN_W +: GAIN_W], base_ovr[g],
                        base_code[g*CODE_W +: CODE_W]};
    assign sig_w[g]  = {sig_gain[g*GAIN_W +: GAIN_W], sig_ovr[g],
                        sig_code[g*CODE_W +: CODE_W]};
  end

  logic [SEL_W-1:0] skip;
  logic [SEL_W-1:0] phys;
  int               idx;

  always_comb begin
    skip = skip_sel[int'(col_idx)*SEL_W +: SEL_W];
    phys = (act_idx >= skip) ? act_idx + 1'b1 : act_idx;
    idx  = int'(col_idx) * SLOTS + int'(phys);
    word_valid = slot_valid[idx];
    if (!word_valid)          word = '0;
    else if (phase == PH_SIG) word = sig_w[idx];
    else                      word = base_w[idx];
  end
endmodule

// File: rtl/colser_shifter.sv
module colser_shifter #(
  parameter int WORD_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  input  logic              scan_first,
  output logic              ser_out,
  output logic              frame_mark,
  output logic              underrun
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      ser_out    <= 1'b0;
      frame_mark <= 1'b0;
      underrun   <= 1'b0;
    end else if (load) begin
      ser_out    <= word[WORD_W-1];
      sh_q       <= {word[WORD_W-2:0], 1'b0};
      frame_mark <= scan_first;
      underrun   <= ~word_valid;
    end else begin
      ser_out    <= sh_q[WORD_W-1];
      sh_q       <= {sh_q[WORD_W-2:0], 1'b0};
      frame_mark <= 1'b0;
    end
  end
endmodule

// File: rtl/colser_lane.sv
module colser_lane
  import colser_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int SLOTS    = 8,
  parameter int GAIN_W   = 2,
  parameter int CODE_W   = 12,
  localparam int WORD_W  = GAIN_W + 1 + CODE_W,
  localparam int NSLOT   = NUM_COLS * SLOTS,
  localparam int COL_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SEL_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSLOT-1:0]          slot_valid,
  input  logic [NSLOT*GAIN_W-1:0]   base_gain,
  input  logic [NSLOT-1:0]          base_ovr,
  input  logic [NSLOT*CODE_W-1:0]   base_code,
  input  logic [NSLOT*GAIN_W-1:0]   sig_gain,
  input  logic [NSLOT-1:0]          sig_ovr,
  input  logic [NSLOT*CODE_W-1:0]   sig_code,
  input  logic [NUM_COLS*SEL_W-1:0] skip_sel,
  output logic                      ser_out,
  output logic                      frame_mark,
  output logic                      underrun
);
  logic [COL_W-1:0]  col_idx;
  logic [SEL_W-1:0]  act_idx;
  phase_e            phase;
  logic              load;
  logic              scan_first;
  logic [WORD_W-1:0] word;
  logic              word_valid;

  colser_seq #(
    .NUM_COLS(NUM_COLS), .SLOTS(SLOTS), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst(rst), .col_idx(col_idx), .act_idx(act_idx),
    .phase(phase), .load(load), .scan_first(scan_first)
  );

  colser_slot_mux #(
    .NUM_COLS(NUM_COLS), .SLOTS(SLOTS), .GAIN_W(GAIN_W), .CODE_W(CODE_W)
  ) u_mux (
    .slot_valid(slot_valid), .base_gain(base_gain), .base_ovr(base_ovr),
    .base_code(base_code), .sig_gain(sig_gain), .sig_ovr(sig_ovr),
    .sig_code(sig_code), .skip_sel(skip_sel), .col_idx(col_idx),
    .act_idx(act_idx), .phase(phase), .word(word), .word_valid(word_valid)
  );

  colser_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk(clk), .rst(rst), .load(load), .word(word), .word_valid(word_valid),
    .scan_first(scan_first), .ser_out(ser_out), .frame_mark(frame_mark),
    .underrun(underrun)
  );
endmodule

// File: rtl/colser_lane_chk.sv
module colser_lane_chk #(
  parameter int NUM_COLS = 32,
  parameter int SLOTS    = 8,
  parameter int WORD_W   = 15,
  localparam int SCAN_LEN = NUM_COLS * (SLOTS - 1) * 2 * WORD_W,
  localparam int CNT_W    = $clog2(SCAN_LEN + 1)
) (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic frame_mark,
  input logic underrun
);
  logic             started;
  logic [CNT_W-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      since   <= '0;
    end else if (frame_mark) begin
      started <= 1'b1;
      since   <= '0;
    end else begin
      since   <= since + 1'b1;
    end
  end

  // R6: an empty slot produces only zero bits
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !ser_out);

  // R6: the underrun flag only changes at word boundaries
  a_r6_flag_per_word: assert property (@(posedge clk) disable iff (rst)
    (started && !frame_mark && ((int'(since) + 2) % WORD_W != 0)) |=> $stable(underrun));

  // R5: marker lasts a single cycle
  a_r5_frame_single: assert property (@(posedge clk) disable iff (rst)
    frame_mark |=> !frame_mark);

  // R7: marker due exactly one scan after the previous one
  a_r7_frame_due: assert property (@(posedge clk) disable iff (rst)
    (started && since == CNT_W'(SCAN_LEN - 1)) |-> frame_mark);

  // R7: no marker before the scan length has elapsed
  a_r7_no_early_frame: assert property (@(posedge clk) disable iff (rst)
    (started && frame_mark) |-> since == CNT_W'(SCAN_LEN - 1));
endmodule

bind colser_lane colser_lane_chk #(
  .NUM_COLS(NUM_COLS), .SLOTS(SLOTS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .ser_out(ser_out), .frame_mark(frame_mark),
  .underrun(underrun)
);

// File: tb/colser_lane_bench.sv
module colser_lane_bench;
  localparam int NC = 32;
  localparam int S  = 8;
  localparam int W  = 15;
  localparam int SW = 3;
  localparam int NS = NC * S;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic [NS-1:0]    slot_valid;
  logic [NS*2-1:0]  base_gain, sig_gain;
  logic [NS-1:0]    base_ovr, sig_ovr;
  logic [NS*12-1:0] base_code, sig_code;
  logic [NC*SW-1:0] skip_sel;
  logic ser_out, frame_mark, underrun;

  colser_lane u_colser_lane (
    .clk(clk), .rst(rst), .slot_valid(slot_valid),
    .base_gain(base_gain), .base_ovr(base_ovr), .base_code(base_code),
    .sig_gain(sig_gain), .sig_ovr(sig_ovr), .sig_code(sig_code),
    .skip_sel(skip_sel), .ser_out(ser_out), .frame_mark(frame_mark),
    .underrun(underrun)
  );

  typedef struct {
    logic [W-1:0] word;
    logic         under;
    logic         first;
    string        req;
  } item_t;

  item_t exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit rst_chk_pending = 0;

  function automatic logic [W-1:0] pack(logic [1:0] g, logic o, logic [11:0] c);
    return {g, o, c};
  endfunction

  task automatic load_pattern(int mode);
    for (int c = 0; c < NC; c++) begin
      case (mode)
        0: skip_sel[c*SW +: SW] = 3'd7;
        1: skip_sel[c*SW +: SW] = 3'(c % 8);
        2: skip_sel[c*SW +: SW] = (c % 3 == 0) ? 3'd7 : 3'(c % 8);
        default: skip_sel[c*SW +: SW] = 3'(7 - (c % 2) * 4);
      endcase
      for (int s = 0; s < S; s++) begin
        int i;
        i = c * S + s;
        slot_valid[i] = (mode == 2) ? ((c * 7 + s) % 5 != 0) : 1'b1;
        if (mode == 3) begin
          base_gain[i*2 +: 2]  = 2'b11;
          base_ovr[i]          = 1'b1;
          base_code[i*12 +: 12] = 12'hFFF;
          sig_gain[i*2 +: 2]   = 2'b10;
          sig_ovr[i]           = 1'b0;
          sig_code[i*12 +: 12] = 12'h801;
        end else begin
          base_gain[i*2 +: 2]  = 2'((c + s) % 4);
          base_ovr[i]          = 1'((c + s) % 2);
          base_code[i*12 +: 12] = 12'((c * 131 + s * 17 + mode * 7) % 4096);
          sig_gain[i*2 +: 2]   = 2'((c + 2 * s + 1) % 4);
          sig_ovr[i]           = 1'(1 - (c + s) % 2);
          sig_code[i*12 +: 12] = 12'((c * 53 + s * 211 + 1000 + mode) % 4096);
        end
      end
    end
  endtask

  task automatic push_scan(string req);
    for (int c = 0; c < NC; c++) begin
      int sk;
      sk = int'(skip_sel[c*SW +: SW]);
      for (int a = 0; a < S - 1; a++) begin
        int p;
        int i;
        p = (a < sk) ? a : a + 1;
        i = c * S + p;
        for (int ph = 0; ph < 2; ph++) begin
          item_t it;
          it.under = !slot_valid[i];
          it.first = (c == 0 && a == 0 && ph == 0);
          it.req   = it.under ? {req, "/R6"} : (it.first ? {req, "/R5"} : req);
          if (!slot_valid[i])  it.word = '0;
          else if (ph == 0)    it.word = pack(base_gain[i*2 +: 2], base_ovr[i], base_code[i*12 +: 12]);
          else                 it.word = pack(sig_gain[i*2 +: 2], sig_ovr[i], sig_code[i*12 +: 12]);
          exp_q.push_back(it);
        end
      end
    end
  endtask

  task automatic run_pattern(int mode, int nscans, string req);
    @(negedge clk);
    rst = 1'b1;
    rst_chk_pending = 1'b1;
    load_pattern(mode);
    repeat (3) @(negedge clk);
    for (int k = 0; k < nscans; k++) push_scan(req);
    rst = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    int bp = 0;
    logic [W-1:0] got = '0;
    bit fr_bad = 0;
    bit un_bad = 0;
    forever begin
      bit live;
      @(posedge clk);
      live = !rst;
      @(negedge clk);
      if (!live) begin
        bp = 0; got = '0; fr_bad = 0; un_bad = 0;
        if (rst_chk_pending) begin
          rst_chk_pending = 0;
          n_tests++;
          if (ser_out !== 1'b0 || frame_mark !== 1'b0 || underrun !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset outputs: actual ser=%b frame=%b under=%b, expected 0 0 0",
                     ser_out, frame_mark, underrun);
          end
        end
      end else if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q[0];
        got[W-1-bp] = ser_out;
        if (frame_mark !== ((bp == 0) && it.first)) fr_bad = 1;
        if (underrun !== it.under) un_bad = 1;
        bp++;
        if (bp == W) begin
          n_tests++;
          if (got !== it.word || fr_bad || un_bad) begin
            n_fail++;
            $display("FAIL %s word: actual %h (frame_err=%0d under_err=%0d), expected %h under=%b first=%b",
                     it.req, got, fr_bad, un_bad, it.word, it.under, it.first);
          end
          void'(exp_q.pop_front());
          bp = 0; got = '0; fr_bad = 0; un_bad = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual stream incomplete with %0d words pending, expected 0",
               exp_q.size());
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    slot_valid = '0; base_gain = '0; base_ovr = '0; base_code = '0;
    sig_gain = '0; sig_ovr = '0; sig_code = '0; skip_sel = '0;
    run_pattern(0, 2, "R1/R2/R3/R7");
    run_pattern(1, 1, "R3/R4");
    run_pattern(2, 1, "R4");
    run_pattern(3, 1, "R1/R2");
    @(negedge clk);
    rst = 1'b1;
    rst_chk_pending = 1'b1;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule